// File: doc/BRIEF.md
# External Interrupt Request Flag

This block turns one active-low external interrupt pin into the request flag that a priority controller reads. The pin first crosses into the clock domain through a short synchronizer chain. A mode input then picks one of two behaviours. In level mode the flag simply follows the inverted, synchronized pin. In transition mode a held flag register is set by a high-to-low change between two successive synchronized samples.

In transition mode the flag stays set until something clears it. The controller clears it by pulsing the vector acknowledge when it dispatches to the service routine. Software can also load it with a write. In level mode neither the acknowledge nor a software write has any effect, because the external source owns the request. While level mode is selected the held register is kept clear, so a change of mode starts from a known state.

Top module: `ext_irq_flag`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `req_flag` is 0. The synchronizer stages reset to the idle (high) pin level.
- R2: With `edge_mode`=0, `req_flag` equals the inverse of `pin_n` as it was sampled SYNC_STAGES clock edges earlier. The default is 2 edges.
- R3: With `edge_mode`=1, a fall of the synchronized pin from 1 to 0 between two successive samples sets `req_flag`. With the default chain, the flag is visible after the third rising edge following the pin fall.
- R4: With `edge_mode`=1, `req_flag` keeps its value when no new fall, write or acknowledge occurs, whatever the pin does.
- R5: With `edge_mode`=1, `vec_ack`=1 clears `req_flag` at the next edge, unless R7 or R9 applies in that cycle.
- R6: With `edge_mode`=0, `vec_ack` has no effect on `req_flag`.
- R7: With `edge_mode`=1 and no fall in the cycle, `sw_wr`=1 loads `sw_data` into the flag at the next edge. A write takes precedence over an acknowledge in the same cycle.
- R8: With `edge_mode`=0, `sw_wr` has no effect on `req_flag`.
- R9: With `edge_mode`=1, a detected fall sets the flag even if `vec_ack` or `sw_wr` with `sw_data`=0 is present in the same cycle.
- R10: While `edge_mode`=0 the held flag is cleared. After a switch to `edge_mode`=1, `req_flag` reads 0 until a new fall or a write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| edge_mode | input | 1 | 1 = transition-activated, 0 = level-activated |
| vec_ack | input | 1 | Pulse from the controller when this interrupt is vectored |
| sw_wr | input | 1 | Software write strobe for the flag |
| sw_data | input | 1 | Value written by software |
| req_flag | output | 1 | Interrupt request flag to the priority controller |

## Verification
The properties assume that `edge_mode`, `vec_ack`, `sw_wr` and `sw_data` are synchronous to `clk`. Only `pin_n` may change freely, because it reaches the checked logic only through the synchronizer. The properties also assume that a change of mode is judged by the mode seen in the cycle after the change. For this reason, every clocked implication on the held flag is excused when `edge_mode` has dropped by the following cycle. The stimulus drives all inputs on the falling clock edge. It keeps the pin low or high for random stretches, so that falls are both isolated and back to back. It toggles the mode only rarely, so that long runs of each mode get checked.

// File: rtl/ext_irq_flag.sv
module ext_irq_flag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic vec_ack,
  input  logic sw_wr,
  input  logic sw_data,
  output logic req_flag
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;
  logic         flag_q;
  logic         pin_lvl;
  logic         fall;

  assign pin_lvl = sync_q[TOP];
  assign fall    = prev_q & ~pin_lvl;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[TOP-1:0], pin_n};
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= pin_n;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         flag_q <= 1'b0;
    else if (!edge_mode) flag_q <= 1'b0;
    else if (fall)      flag_q <= 1'b1;
    else if (sw_wr)     flag_q <= sw_data;
    else if (vec_ack)   flag_q <= 1'b0;

  assign req_flag = edge_mode ? flag_q : ~pin_lvl;
endmodule

module ext_irq_flag_chk (
  input logic clk,
  input logic rst_n,
  input logic edge_mode,
  input logic vec_ack,
  input logic sw_wr,
  input logic sw_data,
  input logic req_flag,
  input logic fall
);
  // R3
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fall) |=> (!edge_mode || req_flag));
  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !fall && !sw_wr && !vec_ack) |=> (!edge_mode || $stable(req_flag)));
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && vec_ack && !fall && !sw_wr) |=> (!edge_mode || !req_flag));
  // R7
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && sw_wr && !fall) |=> (!edge_mode || req_flag == $past(sw_data)));
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fall && (vec_ack || (sw_wr && !sw_data))) |=> (!edge_mode || req_flag));
  // R10
  mode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode) |=> (!edge_mode || !req_flag));
endmodule

bind ext_irq_flag ext_irq_flag_chk chk (
  .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .vec_ack(vec_ack),
  .sw_wr(sw_wr), .sw_data(sw_data), .req_flag(req_flag), .fall(fall)
);

// File: tb/ext_irq_flag_test.sv
module ext_irq_flag_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic edge_mode = 1'b0;
  logic vec_ack = 1'b0;
  logic sw_wr = 1'b0;
  logic sw_data = 1'b0;
  logic req_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  ext_irq_flag uut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .edge_mode(edge_mode),
    .vec_ack(vec_ack), .sw_wr(sw_wr), .sw_data(sw_data), .req_flag(req_flag)
  );

  logic m1, m2, m3, mflag;

  function automatic logic next_flag(logic mode, logic f, logic cur, logic wr,
                                     logic d, logic ack, logic s_now, logic s_old);
    if (!mode) return 1'b0;
    if (s_old && !s_now) return 1'b1;
    if (wr) return d;
    if (ack) return 1'b0;
    return cur;
  endfunction

  function automatic logic expect_out(logic mode, logic f, logic s_now);
    return mode ? f : ~s_now;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= 1'b1; m2 <= 1'b1; m3 <= 1'b1; mflag <= 1'b0;
    end else begin
      m1 <= pin_n; m2 <= m1; m3 <= m2;
      mflag <= next_flag(edge_mode, mflag, mflag, sw_wr, sw_data, vec_ack, m2, m3);
    end

  task automatic check_now();
    logic e;
    e = expect_out(edge_mode, mflag, m2);
    checks++;
    if (req_flag !== e) begin
      errors++;
      $display("FAIL %s: req_flag=%b expected=%b at %0t", tag, req_flag, e, $time);
    end
  endtask

  task automatic step(input logic p, input logic m, input logic a,
                      input logic w, input logic d, input string t, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      tag = t;
      pin_n = p; edge_mode = m; vec_ack = a; sw_wr = w; sw_data = d;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    tag = "R1";
    checks++;
    if (req_flag !== 1'b0) begin
      errors++;
      $display("FAIL R1: req_flag=%b expected=0 in reset", req_flag);
    end
    rst_n = 1'b1;
    step(1, 0, 0, 0, 0, "R1", 2);
    // R2 level tracking
    step(0, 0, 0, 0, 0, "R2", 5);
    step(1, 0, 0, 0, 0, "R2", 5);
    // R6 ack ignored in level mode while pin low
    step(0, 0, 1, 0, 0, "R6", 5);
    step(0, 0, 0, 0, 0, "R6", 2);
    // R8 write ignored in level mode
    step(1, 0, 0, 1, 1, "R8", 4);
    step(0, 0, 0, 1, 0, "R8", 4);
    // R10 switch to edge mode with pin already low: no flag
    step(0, 1, 0, 0, 0, "R10", 5);
    // R3 / R4 edge set and hold
    step(1, 1, 0, 0, 0, "R4", 4);
    step(0, 1, 0, 0, 0, "R3", 5);
    step(1, 1, 0, 0, 0, "R4", 5);
    // R5 acknowledge clears
    step(1, 1, 1, 0, 0, "R5", 1);
    step(1, 1, 0, 0, 0, "R5", 3);
    // R7 software load and precedence over ack
    step(1, 1, 1, 1, 1, "R7", 1);
    step(1, 1, 0, 0, 0, "R7", 2);
    step(1, 1, 0, 1, 0, "R7", 1);
    step(1, 1, 0, 0, 0, "R7", 2);
    // R9 set wins against continuous ack and clearing write
    step(0, 1, 1, 0, 0, "R9", 5);
    step(1, 1, 1, 0, 0, "R9", 4);
    step(0, 1, 0, 1, 0, "R9", 5);
    step(1, 1, 0, 0, 0, "R9", 3);
    // constrained random
    begin
      logic p, m;
      int hold;
      p = 1'b1; m = 1'b1; hold = 0;
      for (int c = 0; c < 4000; c++) begin
        if (hold == 0) begin p = ~p; hold = 1 + ($urandom % 6); end
        hold--;
        if (($urandom % 64) == 0) m = ~m;
        step(p, m, ($urandom % 5) == 0, ($urandom % 7) == 0, $urandom % 2,
             m ? "R3" : "R2", 1);
      end
    end
    step(1, 1, 0, 0, 0, "R4", 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule